// File: doc/BRIEF.md
# Dual-Path Complex Upconverter with Digital Band Summation

The block takes two complex baseband streams, path AB and path CD, each carried as separate real and imaginary samples. The inputs arrive at half the output sample rate and are marked by a valid strobe. Each path raises its sample rate by two. It does this by inserting a zero between input samples and running a fixed half-band low-pass filter. Each path then shifts its band in frequency with its own numerically controlled oscillator and complex mixer. Both the oscillators and the mixers run at the full output rate of one sample per clock.

A mode setting chooses how the two mixed paths leave the block. In split mode each path keeps its own output pair and the two paths do not interact. In summation mode the two mixed signals are added and saturated, and the sum drives output pair A/B while pair C/D stays at zero. This lets one oscillator be tuned to a positive frequency and the other to a negative frequency. The two bands then sit side by side in a single complex output about twice as wide as either input stream.

The frequency words and the mode are loaded together on an update strobe. The same strobe restarts both phase accumulators, so both paths begin phase-aligned. Both paths have the same fixed latency, so the summed bands stay aligned in time.

Top module: `dual_duc_sum`

## Requirements
- R1: While rst_ni is low all four outputs are zero. With zero input after reset they stay zero.
- R2: The interpolated stream of a path is defined as follows. Let s[k] be the input value captured at clock edge k when vld_i is high, and 0 when vld_i is low. Sample n is (-s[n] + 9*s[n-2] + 16*s[n-3] + 9*s[n-4] - s[n-6]) arithmetically shifted right by 4 (floor), as a 13-bit signed value. Edge 1 is the first edge after reset release, and s[k] = 0 for k < 1.
- R3: Each path has a 32-bit phase accumulator. It adds its loaded frequency word on every clock and wraps modulo 2^32. Its top 8 bits p select sin = round(2047*sin(2*pi*(p+0.5)/256)) and cos = round(2047*cos(2*pi*(p+0.5)/256)), with rounding to the nearest integer and ties away from zero.
- R4: The mixer computes re' = floor((re*cos - im*sin)/2048) and im' = floor((re*sin + im*cos)/2048) as 13-bit signed values.
- R5: Define mixed sample n of a path as the R4 result of R2 sample n and the R3 values of the accumulator state after edge n. The outputs seen after edge e then hold mixed sample n = e-3 of each path. Both paths have this same latency.
- R6: In split mode (mode bit 0), A = real and B = imaginary of mixed path AB, and C = real and D = imaginary of mixed path CD.
- R7: In summation mode (mode bit 1), A and B carry the real and imaginary sums of the two mixed paths, and C and D are zero.
- R8: Each summation-mode sum is clamped to the 13-bit signed range [-4096, 4095] instead of wrapping.
- R9: fw_ab_i, fw_cd_i and sum_en_i are loaded only at an edge with upd_i high. At that edge both phase accumulators become zero. Changes on these inputs without the strobe have no effect on the outputs. The output stage uses the mode loaded at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input samples valid this cycle |
| ab_re_i | input | 12 | Path AB real input, signed |
| ab_im_i | input | 12 | Path AB imaginary input, signed |
| cd_re_i | input | 12 | Path CD real input, signed |
| cd_im_i | input | 12 | Path CD imaginary input, signed |
| upd_i | input | 1 | Load words and mode, restart phases |
| fw_ab_i | input | 32 | Path AB frequency word, two's complement |
| fw_cd_i | input | 32 | Path CD frequency word, two's complement |
| sum_en_i | input | 1 | Mode to load: 0 split, 1 summation |
| y_a_o | output | 13 | Output A (real of AB or of sum), signed |
| y_b_o | output | 13 | Output B (imag of AB or of sum), signed |
| y_c_o | output | 13 | Output C (real of CD, zero when summing), signed |
| y_d_o | output | 13 | Output D (imag of CD, zero when summing), signed |

## Verification
Several functions can land in the same cycle. Every configuration run begins with the update strobe on the same edge as a valid input sample. In that cycle the phase restart, the word load and the capture of a new sample all coincide. The mode change also reaches the output stage while the mixers still hold samples formed under the previous configuration. The bench runs a per-edge arithmetic model of the stated equations, so it predicts exactly which output cycle mixes old data under the new mode. It then compares all four outputs on every cycle. Saturation is driven at both rails with full-scale constant inputs, and the bench confirms that clamping occurred.

// File: rtl/duc_pkg.sv
package duc_pkg;
  typedef enum logic {MODE_SPLIT = 1'b0, MODE_SUM = 1'b1} duc_mode_e;
  localparam real PI = 3.14159265358979;
  localparam int HB_SHIFT = 4;
endpackage

// File: rtl/hb_interp2.sv
module hb_interp2 #(
  parameter int IW = 12,
  parameter int OW = IW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [IW-1:0] x_i,
  output logic signed [OW-1:0] y_o
);
  localparam int NT = 7;
  localparam int AW = IW + 6;

  logic signed [IW-1:0] tap_q [NT];
  logic signed [AW-1:0] acc;
  logic signed [OW-1:0] y_q;

  function automatic logic signed [AW-1:0] sx(input logic signed [IW-1:0] v);
    return AW'(v);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NT; k++) tap_q[k] <= '0;
    end else begin
      tap_q[0] <= vld_i ? x_i : '0;  // zero stuffing between strobes
      for (int k = 1; k < NT; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  // half-band taps -1 0 9 16 9 0 -1, scaled by 1/16
  always_comb begin
    acc = ((sx(tap_q[2]) + sx(tap_q[4])) <<< 3) + sx(tap_q[2]) + sx(tap_q[4])
        + (sx(tap_q[3]) <<< 4) - sx(tap_q[0]) - sx(tap_q[6]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else         y_q <= OW'(acc >>> duc_pkg::HB_SHIFT);
  end

  assign y_o = y_q;

  // R2
  hb_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc >>> duc_pkg::HB_SHIFT) <= AW'((1 << (OW-1)) - 1)) &&
    ((acc >>> duc_pkg::HB_SHIFT) >= AW'(-(1 << (OW-1)))));
endmodule

// File: rtl/nco_quarter.sv
module nco_quarter #(
  parameter int PW = 32,
  parameter int LW = 8,
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic [PW-1:0]        fw_i,
  output logic signed [CW-1:0] cos_o,
  output logic signed [CW-1:0] sin_o
);
  localparam int QW  = LW - 2;
  localparam int QN  = 1 << QW;
  localparam int AMP = (1 << (CW-1)) - 1;

  function automatic logic signed [CW-1:0] qsin(input int k);
    real a;
    a = $sin(duc_pkg::PI * (real'(k) + 0.5) / real'(2 * QN));
    return CW'(int'(a * real'(AMP)));
  endfunction

  logic signed [CW-1:0] qtab [QN];
  for (genvar k = 0; k < QN; k++) begin : g_tab
    localparam logic signed [CW-1:0] V = qsin(k);
    assign qtab[k] = V;
  end

  // half-sample offset makes each quadrant a mirror or negation of the table
  function automatic logic signed [CW-1:0] look(input logic [LW-1:0] p);
    logic [QW-1:0]        ix;
    logic signed [CW-1:0] m;
    ix = p[QW] ? ~p[QW-1:0] : p[QW-1:0];
    m  = qtab[ix];
    return p[LW-1] ? -m : m;
  endfunction

  logic [PW-1:0]        fw_q, ph_q;
  logic [LW-1:0]        p_sin, p_cos;
  logic signed [CW-1:0] cos_q, sin_q;

  assign p_sin = ph_q[PW-1 -: LW];
  assign p_cos = p_sin + LW'(QN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fw_q  <= '0;
      ph_q  <= '0;
      cos_q <= '0;
      sin_q <= '0;
    end else begin
      if (upd_i) begin
        fw_q <= fw_i;
        ph_q <= '0;
      end else begin
        ph_q <= ph_q + fw_q;
      end
      cos_q <= look(p_cos);
      sin_q <= look(p_sin);
    end
  end

  assign cos_o = cos_q;
  assign sin_o = sin_q;

  // R3
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ph_q == $past(ph_q + fw_q));
  // R9
  fw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(fw_q));
  // R3
  trig_amp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_q <= CW'(AMP)) && (cos_q >= -CW'(AMP)) && (sin_q <= CW'(AMP)) && (sin_q >= -CW'(AMP)));
endmodule

// File: rtl/cplx_mix.sv
module cplx_mix #(
  parameter int DW = 13,
  parameter int CW = 12,
  parameter int OW = DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] re_i,
  input  logic signed [DW-1:0] im_i,
  input  logic signed [CW-1:0] cos_i,
  input  logic signed [CW-1:0] sin_i,
  output logic signed [OW-1:0] re_o,
  output logic signed [OW-1:0] im_o
);
  localparam int MW = DW + CW + 1;
  localparam logic signed [MW-1:0] O_MAX = MW'((1 << (OW-1)) - 1);
  localparam logic signed [MW-1:0] O_MIN = MW'(-(1 << (OW-1)));

  logic signed [MW-1:0] p_re, p_im, sh_re, sh_im;
  logic signed [OW-1:0] re_q, im_q;

  always_comb begin
    p_re  = MW'(re_i) * MW'(cos_i) - MW'(im_i) * MW'(sin_i);
    p_im  = MW'(re_i) * MW'(sin_i) + MW'(im_i) * MW'(cos_i);
    sh_re = p_re >>> (CW-1);
    sh_im = p_im >>> (CW-1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q <= '0;
      im_q <= '0;
    end else begin
      re_q <= OW'(sh_re);
      im_q <= OW'(sh_im);
    end
  end

  assign re_o = re_q;
  assign im_o = im_q;

  // R4
  mix_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_re <= O_MAX) && (sh_re >= O_MIN) && (sh_im <= O_MAX) && (sh_im >= O_MIN));
endmodule

// File: rtl/dual_duc_sum.sv
module dual_duc_sum #(
  parameter int IN_W   = 12,
  parameter int PH_W   = 32,
  parameter int LUT_W  = 8,
  parameter int TRIG_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic signed [IN_W-1:0]    ab_re_i,
  input  logic signed [IN_W-1:0]    ab_im_i,
  input  logic signed [IN_W-1:0]    cd_re_i,
  input  logic signed [IN_W-1:0]    cd_im_i,
  input  logic                      upd_i,
  input  logic [PH_W-1:0]           fw_ab_i,
  input  logic [PH_W-1:0]           fw_cd_i,
  input  logic                      sum_en_i,
  output logic signed [IN_W:0]      y_a_o,
  output logic signed [IN_W:0]      y_b_o,
  output logic signed [IN_W:0]      y_c_o,
  output logic signed [IN_W:0]      y_d_o
);
  import duc_pkg::*;

  localparam int NP    = 2;
  localparam int MIX_W = IN_W + 1;
  localparam int OUT_W = MIX_W;
  localparam int SUM_W = MIX_W + 1;
  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] S_MIN = SUM_W'(-(1 << (OUT_W-1)));
  localparam logic signed [OUT_W-1:0] O_MAX = OUT_W'((1 << (OUT_W-1)) - 1);

  logic signed [IN_W-1:0]   src_re [NP];
  logic signed [IN_W-1:0]   src_im [NP];
  logic [PH_W-1:0]          fw_sel [NP];
  logic signed [MIX_W-1:0]  hb_re  [NP];
  logic signed [MIX_W-1:0]  hb_im  [NP];
  logic signed [TRIG_W-1:0] nco_c  [NP];
  logic signed [TRIG_W-1:0] nco_s  [NP];
  logic signed [MIX_W-1:0]  mx_re  [NP];
  logic signed [MIX_W-1:0]  mx_im  [NP];

  assign src_re[0] = ab_re_i;
  assign src_im[0] = ab_im_i;
  assign src_re[1] = cd_re_i;
  assign src_im[1] = cd_im_i;
  assign fw_sel[0] = fw_ab_i;
  assign fw_sel[1] = fw_cd_i;

  for (genvar p = 0; p < NP; p++) begin : g_path
    hb_interp2 #(.IW(IN_W), .OW(MIX_W)) u_hb_re (
      .clk_i, .rst_ni, .vld_i, .x_i(src_re[p]), .y_o(hb_re[p]));
    hb_interp2 #(.IW(IN_W), .OW(MIX_W)) u_hb_im (
      .clk_i, .rst_ni, .vld_i, .x_i(src_im[p]), .y_o(hb_im[p]));
    nco_quarter #(.PW(PH_W), .LW(LUT_W), .CW(TRIG_W)) u_nco (
      .clk_i, .rst_ni, .upd_i, .fw_i(fw_sel[p]), .cos_o(nco_c[p]), .sin_o(nco_s[p]));
    cplx_mix #(.DW(MIX_W), .CW(TRIG_W), .OW(MIX_W)) u_mix (
      .clk_i, .rst_ni, .re_i(hb_re[p]), .im_i(hb_im[p]),
      .cos_i(nco_c[p]), .sin_i(nco_s[p]), .re_o(mx_re[p]), .im_o(mx_im[p]));
  end

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [SUM_W-1:0] v);
    if (v > S_MAX) return OUT_W'(S_MAX);
    if (v < S_MIN) return OUT_W'(S_MIN);
    return OUT_W'(v);
  endfunction

  duc_mode_e                mode_q;
  logic signed [SUM_W-1:0]  sum_re, sum_im;
  logic signed [OUT_W-1:0]  ya_q, yb_q, yc_q, yd_q;

  assign sum_re = SUM_W'(mx_re[0]) + SUM_W'(mx_re[1]);
  assign sum_im = SUM_W'(mx_im[0]) + SUM_W'(mx_im[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_SPLIT;
    else if (upd_i) mode_q <= duc_mode_e'(sum_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ya_q <= '0;
      yb_q <= '0;
      yc_q <= '0;
      yd_q <= '0;
    end else if (mode_q == MODE_SUM) begin
      ya_q <= sat(sum_re);
      yb_q <= sat(sum_im);
      yc_q <= '0;
      yd_q <= '0;
    end else begin
      ya_q <= mx_re[0];
      yb_q <= mx_im[0];
      yc_q <= mx_re[1];
      yd_q <= mx_im[1];
    end
  end

  assign y_a_o = ya_q;
  assign y_b_o = yb_q;
  assign y_c_o = yc_q;
  assign y_d_o = yd_q;

  // R7
  cd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SUM) |=> (y_c_o == '0) && (y_d_o == '0));
  // R6
  split_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SPLIT) |=> (y_c_o == $past(mx_re[1])) && (y_a_o == $past(mx_re[0])));
  // R8
  sat_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SUM && sum_im > S_MAX) |=> y_b_o == O_MAX);
  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(mode_q));
endmodule

// File: tb/dual_duc_sum_test.sv
`timescale 1ns/1ps
module dual_duc_sum_test;
  localparam int NE = 4096;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vld_i = 1'b0, upd_i = 1'b0, sum_en_i = 1'b0;
  logic signed [11:0] ab_re_i = '0, ab_im_i = '0, cd_re_i = '0, cd_im_i = '0;
  logic [31:0] fw_ab_i = '0, fw_cd_i = '0;
  logic signed [12:0] y_a_o, y_b_o, y_c_o, y_d_o;

  always #10 clk = ~clk;

  dual_duc_sum uut (
    .clk_i(clk), .rst_ni, .vld_i, .ab_re_i, .ab_im_i, .cd_re_i, .cd_im_i,
    .upd_i, .fw_ab_i, .fw_cd_i, .sum_en_i, .y_a_o, .y_b_o, .y_c_o, .y_d_o);

  int n_chk = 0, n_err = 0, n_clamp = 0, e = 0;
  int s_re [2][NE];
  int s_im [2][NE];
  int unsigned ph_m [2][NE];
  int unsigned fwq [2];
  bit md [NE];
  int unsigned rng = 32'h1ACE_B00C;
  string ptag = "";
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s edge %0d got %0d exp %0d", ptag, tag, e, got, exp);
    end
  endtask

  function automatic int rnd12();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return int'($signed(rng[11:0]));
  endfunction

  function automatic int tsin(input int p);
    return int'(2047.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 256.0));
  endfunction

  function automatic int sv(input int p, input int rail, input int k);
    if (k < 1) return 0;
    return rail == 0 ? s_re[p][k] : s_im[p][k];
  endfunction

  function automatic int filt(input int p, input int rail, input int n);
    return (-sv(p,rail,n) + 9*sv(p,rail,n-2) + 16*sv(p,rail,n-3)
            + 9*sv(p,rail,n-4) - sv(p,rail,n-6)) >>> 4;
  endfunction

  task automatic mixed(input int p, input int n, output int r, output int i);
    int fr, fi, pp, c, s;
    if (n < 1) begin r = 0; i = 0; return; end
    fr = filt(p, 0, n);
    fi = filt(p, 1, n);
    pp = int'(ph_m[p][n] >> 24);
    s  = tsin(pp);
    c  = tsin((pp + 64) % 256);
    r  = (fr * c - fi * s) >>> 11;
    i  = (fr * s + fi * c) >>> 11;
  endtask

  function automatic int sat13(input int v);
    if (v > 4095) return 4095;
    if (v < -4096) return -4096;
    return v;
  endfunction

  task automatic verify();
    int ra, ia, rc, ic, sa, sb;
    mixed(0, e - 3, ra, ia);
    mixed(1, e - 3, rc, ic);
    if (!md[e-1]) begin
      chk("R2 R3 R4 R5 R6 A", int'(y_a_o), ra);
      chk("R2 R3 R4 R5 R6 B", int'(y_b_o), ia);
      chk("R5 R6 C", int'(y_c_o), rc);
      chk("R5 R6 D", int'(y_d_o), ic);
    end else begin
      sa = sat13(ra + rc);
      sb = sat13(ia + ic);
      if (sa != ra + rc || sb != ia + ic) n_clamp++;
      chk((sa != ra + rc) ? "R7 R8 A" : "R7 A", int'(y_a_o), sa);
      chk((sb != ia + ic) ? "R7 R8 B" : "R7 B", int'(y_b_o), sb);
      chk("R7 C", int'(y_c_o), 0);
      chk("R7 D", int'(y_d_o), 0);
    end
  endtask

  task automatic step(input bit vld, input int ar, input int ai, input int cr, input int ci,
                      input bit upd, input int unsigned fa, input int unsigned fc, input bit sm);
    vld_i = vld; ab_re_i = 12'(ar); ab_im_i = 12'(ai); cd_re_i = 12'(cr); cd_im_i = 12'(ci);
    upd_i = upd; fw_ab_i = fa; fw_cd_i = fc; sum_en_i = sm;
    s_re[0][e+1] = vld ? ar : 0;  s_im[0][e+1] = vld ? ai : 0;
    s_re[1][e+1] = vld ? cr : 0;  s_im[1][e+1] = vld ? ci : 0;
    for (int p = 0; p < 2; p++) ph_m[p][e+1] = upd ? 0 : ph_m[p][e] + fwq[p];
    if (upd) begin fwq[0] = fa; fwq[1] = fc; end
    md[e+1] = upd ? sm : md[e];
    @(posedge clk);
    e++;
    @(negedge clk);
    verify();
  endtask

  // one configuration run; the strobe shares its edge with a valid sample
  task automatic run(input int unsigned fa, input int unsigned fc, input bit sm,
                     input int len, input int kind);
    for (int j = 0; j < len; j++) begin
      bit v;
      int ar, ai, cr, ci;
      v = (j % 2 == 0) && (kind != 1 || ((j / 16) % 4) != 3);
      if (kind == 2)      begin ar = 2047;  ai = 2047;  cr = 2047;  ci = 2047;  end
      else if (kind == 3) begin ar = -2048; ai = -2048; cr = -2048; ci = -2048; end
      else begin ar = rnd12(); ai = rnd12(); cr = rnd12(); ci = rnd12(); end
      step(v, ar, ai, cr, ci, j == 0, fa, fc, sm);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned wa [6];
    int unsigned wc [6];
    wa = '{32'h0, 32'h2000_0000, 32'h4000_0000, 32'h0123_4567, 32'hE000_0000, 32'h0800_0000};
    wc = '{32'h0, 32'hE000_0000, 32'hC000_0000, 32'hF9AB_CDEF, 32'h2000_0000, 32'h7000_0000};
    for (int p = 0; p < 2; p++) begin ph_m[p][0] = 0; fwq[p] = 0; end
    md[0] = 0;

    // R1: outputs held at zero in reset even with busy inputs
    vld_i = 1; ab_re_i = 12'sd1000; ab_im_i = -12'sd700; cd_re_i = 12'sd55; cd_im_i = 12'sd9;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 A", int'(y_a_o), 0);
      chk("R1 B", int'(y_b_o), 0);
      chk("R1 C", int'(y_c_o), 0);
      chk("R1 D", int'(y_d_o), 0);
    end
    rst_ni = 1'b1;

    // R1: quiet input after reset keeps outputs at zero
    ptag = "R1";
    for (int k = 0; k < 8; k++) step(1'b1, 0, 0, 0, 0, 1'b0, 0, 0, 1'b0);
    ptag = "";

    for (int i = 0; i < 6; i++) begin
      run(wa[i], wc[i], 1'b0, 200, i % 2);
      run(wa[i], wc[i], 1'b1, 200, (i + 1) % 2);
    end

    // R8: full-scale constant input, both paths aligned, in both rails
    run(32'h0, 32'h0, 1'b1, 60, 2);
    run(32'h0, 32'h0, 1'b1, 60, 3);
    run(32'hE000_0000, 32'hE000_0000, 1'b1, 80, 2);

    // R9: words and mode wiggle without the strobe
    run(32'h1000_0000, 32'hF000_0000, 1'b0, 4, 0);
    ptag = "R9";
    for (int j = 0; j < 200; j++)
      step(j % 2 == 0, rnd12(), rnd12(), rnd12(), rnd12(), 1'b0,
           32'h0F0F_0000 * j, 32'h1357_9BDF ^ j, j % 3 == 0);
    ptag = "";
    run(32'h1000_0000, 32'hF000_0000, 1'b1, 4, 0);
    ptag = "R9";
    for (int j = 0; j < 100; j++)
      step(j % 2 == 0, rnd12(), rnd12(), rnd12(), rnd12(), 1'b0,
           32'hDEAD_0000 + j, 32'h0000_BEEF * j, j % 2 == 1);
    ptag = "";

    chk("R8 clamp exercised", int'(n_clamp > 0), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule